// File: doc/BRIEF.md
# Programmable Digital Input Qualifier

This block cleans up one asynchronous digital input pin before the rest of the chip sees it. The raw pin is first brought into the system clock domain through a short flop chain. A selectable filter then decides when the clean output level may change. The filter can be a plain synchronizer, or it can require three or six consecutive samples that agree on a new level. It can also be bypassed completely, so that the pin drives the output with no clocked path at all.

The filter does not look at the pin on every clock. A programmable strobe sets how often it takes a sample. A period setting of N above zero gives one sample every 2×N clocks, and a setting of zero gives a sample on every clock. A short glitch therefore has to outlast several sample intervals before it can reach the output. The block is one bit wide. A port is built by placing one copy per pin.

Top module: `pin_qualifier`

## Requirements
- R1: While reset is asserted, and after it is released, qualOut is 0 and the mode tracking starts at synchronize-only (modeSel = 2'b00), with the consecutive-sample count cleared.
- R2: In synchronize-only mode (modeSel = 2'b00), a change on pinIn appears on qualOut after exactly 3 rising clock edges (two synchronizer flops and the output register), with no filtering.
- R3: In 3-sample mode (modeSel = 2'b01), qualOut takes a new level at the edge where the third consecutive sample of that level is taken. With period 0 this is 5 edges after the pin change.
- R4: A run of differing samples shorter than the required depth leaves qualOut unchanged, and a sample that matches the current output drops the partial count.
- R5: In 6-sample mode (modeSel = 2'b10), qualOut changes only after six consecutive samples of the new level. With period 0 this is 8 edges after the pin change.
- R6: For a period setting N > 0, one sample is taken every 2×N clocks, and the strobe counter restarts when the setting changes. In 3-sample mode with N = 2, the latency from the pin change is 11 to 14 edges, depending on the strobe phase.
- R7: A period setting of 0 takes a sample on every clock.
- R8: In asynchronous mode (modeSel = 2'b11), qualOut equals pinIn combinationally, without any clock edge.
- R9: A change of modeSel clears the consecutive-sample count and holds qualOut. In synchronize-only and asynchronous modes, the held level follows the synchronized pin.
- R10: In the qualifying modes, qualOut does not change on any clock without a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Raw asynchronous pin level |
| modeSel | input | 2 | 00 sync only, 01 three samples, 10 six samples, 11 asynchronous |
| periodSel | input | 8 | Sampling period N: a sample every 2×N clocks, every clock when 0 |
| qualOut | output | 1 | Qualified pin level |

## Verification
Directed steps on a quiet pin measure the exact edge count from a pin change to the output change in each mode and at period 0 and 2. These counts separate the synchronizer depth, the qualification depth and the strobe spacing from one another. Short pulses of two and five cycles show that a run just below the required depth is rejected in each filtering mode. A mode switch in the middle of a run shows that the partial count is cleared. Random pin activity with random modes and periods is then compared cycle by cycle against a bench reference model. This catches mistakes at strobe restarts and on mode transitions.

// File: rtl/qual_pkg.sv
package qual_pkg;

  typedef enum logic [1:0] {
    MODE_SYNC  = 2'b00,
    MODE_QUAL3 = 2'b01,
    MODE_QUAL6 = 2'b10,
    MODE_ASYNC = 2'b11
  } qualMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic sampleStb;   // take one qualification sample this cycle
    logic clearMatch;  // mode changed: drop the partial run
  } qualCtl_t;

endpackage

// File: rtl/qual_ctrl.sv
module qual_ctrl
  import qual_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          modeSel,
  input  logic [PERIOD_W-1:0] periodSel,
  output qualCtl_t            ctl
);

  localparam int TICK_W = PERIOD_W + 1;

  logic [PERIOD_W-1:0] periodQ;
  logic [1:0]          modeQ;
  logic [TICK_W-1:0]   tickCnt;
  logic [TICK_W-1:0]   tickLimit;
  logic                periodMoved;
  logic                modeMoved;

  // A sample every 2*N clocks, or every clock for N = 0
  always_comb begin
    if (periodSel == '0) tickLimit = '0;
    else                 tickLimit = {periodSel, 1'b0} - TICK_W'(1);
  end

  assign periodMoved = (periodSel != periodQ);
  assign modeMoved   = (modeSel != modeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '0;
      modeQ   <= MODE_SYNC;
      tickCnt <= '0;
    end else begin
      periodQ <= periodSel;
      modeQ   <= modeSel;
      if (periodMoved || (tickCnt >= tickLimit)) tickCnt <= '0;
      else                                       tickCnt <= tickCnt + TICK_W'(1);
    end
  end

  assign ctl.sampleStb  = (tickCnt >= tickLimit) && !periodMoved;
  assign ctl.clearMatch = modeMoved;

endmodule

// File: rtl/qual_dp.sv
module qual_dp
  import qual_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int SHALLOW_COUNT = 3,
  parameter int DEEP_COUNT    = 6,
  localparam int CNT_W        = $clog2(DEEP_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic [1:0]       modeSel,
  input  qualCtl_t         ctl,
  output logic             levelQ,
  output logic [CNT_W-1:0] matchCnt,
  output logic             qualOut
);

  localparam logic [CNT_W-1:0] NEED_SHALLOW = CNT_W'(SHALLOW_COUNT);
  localparam logic [CNT_W-1:0] NEED_DEEP    = CNT_W'(DEEP_COUNT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncTail;
  logic [CNT_W-1:0]       needCnt;
  logic                   qualifying;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  assign syncTail   = syncQ[SYNC_STAGES-1];
  assign qualifying = (modeSel == MODE_QUAL3) || (modeSel == MODE_QUAL6);
  assign needCnt    = (modeSel == MODE_QUAL6) ? NEED_DEEP : NEED_SHALLOW;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ   <= 1'b0;
      matchCnt <= '0;
    end else if (!qualifying) begin
      levelQ   <= syncTail;
      matchCnt <= '0;
    end else if (ctl.clearMatch) begin
      matchCnt <= '0;
    end else if (ctl.sampleStb) begin
      if (syncTail == levelQ) begin
        matchCnt <= '0;
      end else if (matchCnt + CNT_W'(1) >= needCnt) begin
        levelQ   <= syncTail;
        matchCnt <= '0;
      end else begin
        matchCnt <= matchCnt + CNT_W'(1);
      end
    end
  end

  assign qualOut = (modeSel == MODE_ASYNC) ? pinIn : levelQ;

endmodule

// File: rtl/pin_qualifier.sv
module pin_qualifier
  import qual_pkg::*;
#(
  parameter int PERIOD_W      = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int SHALLOW_COUNT = 3,
  parameter int DEEP_COUNT    = 6,
  localparam int CNT_W        = $clog2(DEEP_COUNT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinIn,
  input  logic [1:0]          modeSel,
  input  logic [PERIOD_W-1:0] periodSel,
  output logic                qualOut
);

  qualCtl_t         ctl;
  logic             levelQ;
  logic [CNT_W-1:0] matchCnt;

  qual_ctrl #(.PERIOD_W(PERIOD_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .periodSel (periodSel),
    .ctl       (ctl)
  );

  qual_dp #(
    .SYNC_STAGES   (SYNC_STAGES),
    .SHALLOW_COUNT (SHALLOW_COUNT),
    .DEEP_COUNT    (DEEP_COUNT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .modeSel  (modeSel),
    .ctl      (ctl),
    .levelQ   (levelQ),
    .matchCnt (matchCnt),
    .qualOut  (qualOut)
  );

endmodule

// File: rtl/pin_qualifier_chk.sv
module pin_qualifier_chk
  import qual_pkg::*;
#(
  parameter int PERIOD_W   = 8,
  parameter int DEEP_COUNT = 6,
  localparam int CNT_W     = $clog2(DEEP_COUNT + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                pinIn,
  input logic [1:0]          modeSel,
  input logic [PERIOD_W-1:0] periodSel,
  input logic                qualOut,
  input qualCtl_t            ctl,
  input logic                levelQ,
  input logic [CNT_W-1:0]    matchCnt
);

  logic inQual;
  assign inQual = (modeSel == MODE_QUAL3) || (modeSel == MODE_QUAL6);

  p_hold_between_strobes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inQual && !ctl.sampleStb) |=> $stable(levelQ));

  p_every_clock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (periodSel == '0 && $past(periodSel) == '0) |-> ctl.sampleStb);

  p_async_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_ASYNC) |-> (qualOut == pinIn));

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    matchCnt < CNT_W'(DEEP_COUNT));

  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearMatch |=> (matchCnt == '0));

endmodule

bind pin_qualifier pin_qualifier_chk #(.PERIOD_W(PERIOD_W), .DEEP_COUNT(DEEP_COUNT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pinIn     (pinIn),
  .modeSel   (modeSel),
  .periodSel (periodSel),
  .qualOut   (qualOut),
  .ctl       (ctl),
  .levelQ    (levelQ),
  .matchCnt  (matchCnt)
);

// File: tb/tb_pin_qualifier.sv
`timescale 1ns/1ps
module tb_pin_qualifier;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [7:0] periodSel = 8'd0;
  logic       qualOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #4 clk = ~clk;  // 125 MHz

  pin_qualifier dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .modeSel(modeSel), .periodSel(periodSel), .qualOut(qualOut)
  );

  // ---------------- reference model built from the requirements ----------
  logic       mS1, mS2, mLvl, mPer0;
  int         mRun, mRem;
  logic [7:0] mPer;
  logic [1:0] mMode;

  function automatic int spanOf(input logic [7:0] n);
    return (n == 0) ? 0 : 2 * int'(n) - 1;
  endfunction

  function automatic int depthOf(input logic [1:0] m);
    return (m == 2'b10) ? 6 : 3;
  endfunction

  assign mPer0 = (mRem == 0) && (periodSel == mPer);  // strobe this cycle

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mLvl <= 0; mRun <= 0; mRem <= 0; mPer <= 0; mMode <= 0;
    end else begin
      mS1 <= pinIn; mS2 <= mS1;
      mPer <= periodSel; mMode <= modeSel;
      if (periodSel != mPer || mRem == 0) mRem <= spanOf(periodSel);
      else                                mRem <= mRem - 1;
      if (modeSel == 2'b00 || modeSel == 2'b11) begin
        mLvl <= mS2; mRun <= 0;
      end else if (modeSel != mMode) begin
        mRun <= 0;
      end else if (mPer0) begin
        if (mS2 == mLvl)                       mRun <= 0;
        else if (mRun + 1 >= depthOf(modeSel)) begin mLvl <= mS2; mRun <= 0; end
        else                                   mRun <= mRun + 1;
      end
    end
  end

  function automatic logic expOut();
    return (modeSel == 2'b11) ? pinIn : mLvl;
  endfunction

  function automatic string tagOf(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock, then compare the output against the model away from the edge
  task automatic step();
    @(posedge clk); #1;
    check(tagOf(modeSel), qualOut, expOut());
  endtask

  task automatic settle(input logic [1:0] m, input logic [7:0] p);
    modeSel = 2'b00; pinIn = 1'b0;
    repeat (6) step();
    modeSel = m; periodSel = p;
    repeat (20) step();
  endtask

  // raise the pin and count edges until the output rises
  task automatic measure(input string tag, input logic [1:0] m, input logic [7:0] p,
                         input logic [1:0] m2, input int lo, input int hi);
    int edges = 0;
    settle(m, p);
    pinIn = 1'b1;
    while (qualOut == 1'b0 && edges < 40) begin
      step(); edges++;
      if (edges == 4) modeSel = m2;
    end
    chkCnt++;
    if (edges < lo || edges > hi) begin
      errCnt++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d edges", tag, edges, lo, hi);
    end
  endtask

  task automatic pulse(input string tag, input logic [1:0] m, input int width);
    settle(m, 8'd0);
    pinIn = 1'b1;
    repeat (width) step();
    pinIn = 1'b0;
    repeat (12) begin
      step();
      check(tag, qualOut, 0);
    end
  endtask

  initial begin : watchdog
    #1_000_000;
    errCnt++; chkCnt++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", qualOut, 0);
    pinIn = 1'b1;
    #1 check("R1", qualOut, 0);
    pinIn = 1'b0;
    rstN = 1'b1;
    step();
    check("R1", qualOut, 0);

    measure("R2", 2'b00, 8'd0, 2'b00, 3, 3);
    measure("R3", 2'b01, 8'd0, 2'b01, 5, 5);
    measure("R7", 2'b01, 8'd0, 2'b01, 5, 5);
    measure("R5", 2'b10, 8'd0, 2'b10, 8, 8);
    measure("R6", 2'b01, 8'd2, 2'b01, 11, 14);
    measure("R9", 2'b10, 8'd0, 2'b01, 8, 8);

    pulse("R4", 2'b01, 2);
    pulse("R4", 2'b10, 5);

    // R10: pin change between strobes with long period
    settle(2'b01, 8'd50);
    pinIn = 1'b1; repeat (3) step(); pinIn = 1'b0;
    repeat (120) begin step(); check("R10", qualOut, 0); end

    // R8: combinational pass-through
    modeSel = 2'b11;
    for (int i = 0; i < 8; i++) begin
      pinIn = ~pinIn; #1;
      check("R8", qualOut, pinIn);
      #2;
    end

    // random activity compared with the model every cycle
    for (int seg = 0; seg < 60; seg++) begin
      int len;
      modeSel = 2'($urandom % 4);
      case ($urandom % 5)
        0, 1: periodSel = 8'd0;
        2: periodSel = 8'd1;
        3: periodSel = 8'd2;
        default: periodSel = 8'd3;
      endcase
      len = 20 + int'($urandom % 60);
      for (int c = 0; c < len; c++) begin
        if ($urandom % 6 == 0) pinIn = ~pinIn;
        step();
      end
    end

    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule